// File: doc/BRIEF.md
# Xon/Xoff In-Band Flow Controller

This block manages in-band (character based) flow control for one serial channel. On the receive side it watches the fill level of the receive FIFO. When the level reaches the halt threshold it queues a stop character for the far end. When the level later falls to the resume threshold it queues a start character. The same two thresholds also serve the hardware handshake logic elsewhere in the channel. Each incoming byte is compared against the programmed start and stop codes. A match is consumed and changes the local pause state, and every other byte is passed on to the FIFO write port.

On the transmit side the block sits between the data source and the character transmitter. It raises a request with the character to send. The transmitter grants at a character boundary. A queued flow-control character always wins over pending data. While the far end has paused this channel, data is held back but locally generated control characters still go out. An optional mode lets any received non-control byte lift the pause; that byte is still stored.

Top module: `swfc_ctrl`

## Requirements
- R1: After reset, tx_req, dat_take, fifo_wr_en (with rx_valid low) and tx_paused are all 0.
- R2: When enabled and not already halted, a FIFO level at or above cfg_halt_lvl makes the block request, from the next cycle on, a control character with tx_is_ctrl=1 and tx_char equal to cfg_xoff_code.
- R3: Exactly one stop character is sent per crossing of the halt threshold. No further stop character is queued until a start character has been queued after the level fell to the resume threshold.
- R4: After a stop character, a level at or below cfg_resume_lvl (configured below cfg_halt_lvl) queues one start character, with tx_char equal to cfg_xon_code, from the next cycle on.
- R5: A queued control character has priority over pending data: while it waits, tx_char carries the control code, tx_is_ctrl=1 and dat_take=0.
- R6: dat_take is high only in a cycle where tx_gnt is high, data is offered and the data character is the one selected.
- R7: A received byte equal to cfg_xoff_code is not written to the FIFO (fifo_wr_en=0) and sets tx_paused from the next cycle.
- R8: A received byte equal to cfg_xon_code (and not equal to the stop code) is not written and clears tx_paused from the next cycle.
- R9: While tx_paused is 1, offered data is not requested (tx_req=0 with no control pending), but locally generated control characters are still requested.
- R10: With cfg_any_resume=1, any other received byte clears tx_paused from the next cycle and is written to the FIFO.
- R11: With cfg_any_resume=0, any other received byte is written to the FIFO and leaves tx_paused unchanged.
- R12: With cfg_enable=0, every received byte is written, no control character is requested and tx_paused is 0.
- R13: The start and stop codes are taken from cfg_xon_code and cfg_xoff_code for any pair of distinct values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Software flow control enable |
| cfg_any_resume | input | 1 | Any received byte lifts a pause |
| cfg_xon_code | input | DATA_W | Start character code |
| cfg_xoff_code | input | DATA_W | Stop character code |
| cfg_halt_lvl | input | LVL_W | FIFO level that triggers a stop character |
| cfg_resume_lvl | input | LVL_W | FIFO level that triggers a start character |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DATA_W | Received byte |
| rx_fifo_level | input | LVL_W | Current receive FIFO fill level |
| fifo_wr_en | output | 1 | Write strobe to the receive FIFO |
| fifo_wr_data | output | DATA_W | Byte written to the receive FIFO |
| dat_valid | input | 1 | A data character is waiting to be sent |
| dat_char | input | DATA_W | Waiting data character |
| dat_take | output | 1 | Data character accepted by the transmitter |
| tx_req | output | 1 | Character available for the transmitter |
| tx_char | output | DATA_W | Character offered to the transmitter |
| tx_is_ctrl | output | 1 | Offered character is a flow-control code |
| tx_gnt | input | 1 | Transmitter takes the offered character at a boundary |
| tx_paused | output | 1 | Transmit data is paused by a received stop code |

## Verification
The bench sweeps every halt threshold from 1 to 64 and ramps the FIFO level up and down. It expects exactly one stop code at the halt level and one start code at the resume level. A design with an off-by-one compare would fire a level early or late, and one missing the halted flag would repeat stop codes. Code pairs are swept across the byte range to catch a stuck or swapped code comparator. The bench also checks the corners where data and a control character compete, and where a pause meets a local stop code. A wrong arbiter would leak data ahead of the control code, or would block the stop code while paused. The two resume modes are checked for whether the trigger byte is stored and whether the pause lifts.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
   typedef enum logic {
      CK_XOFF = 1'b0,
      CK_XON  = 1'b1
   } ctrl_kind_e;
endpackage

// File: rtl/swfc_rx_filter.sv
module swfc_rx_filter #(
   parameter int DATA_W        = 8,
   parameter bit ANY_RESUME_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              any_resume,
   input  logic [DATA_W-1:0] xon_code,
   input  logic [DATA_W-1:0] xoff_code,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              paused
);
   logic hit_xoff, hit_xon, other, any_ok;

   assign hit_xoff = enable && rx_valid && (rx_data == xoff_code);
   assign hit_xon  = enable && rx_valid && (rx_data == xon_code) && !hit_xoff;
   assign other    = rx_valid && !hit_xoff && !hit_xon;

   generate
      if (ANY_RESUME_EN) begin : g_any
         assign any_ok = any_resume;
      end else begin : g_no_any
         assign any_ok = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                paused <= 1'b0;
      else if (!enable)          paused <= 1'b0;
      else if (hit_xoff)         paused <= 1'b1;
      else if (hit_xon)          paused <= 1'b0;
      else if (other && any_ok)  paused <= 1'b0;
   end

   assign wr_en   = other;
   assign wr_data = rx_data;

   // R7
   xoff_pauses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && rx_valid && rx_data == xoff_code) |=> paused);
   // R8
   xon_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && rx_valid && rx_data == xon_code && rx_data != xoff_code) |=> !paused);
endmodule

// File: rtl/swfc_level_mon.sv
module swfc_level_mon
   import swfc_pkg::*;
#(
   parameter int LVL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] halt_lvl,
   input  logic [LVL_W-1:0] resume_lvl,
   input  logic             ack,
   output logic             pend_v,
   output ctrl_kind_e       pend_kind
);
   logic halted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted    <= 1'b0;
         pend_v    <= 1'b0;
         pend_kind <= CK_XOFF;
      end else if (!enable) begin
         halted    <= 1'b0;
         pend_v    <= 1'b0;
         pend_kind <= CK_XOFF;
      end else if (!pend_v) begin
         if (!halted && level >= halt_lvl) begin
            halted    <= 1'b1;
            pend_v    <= 1'b1;
            pend_kind <= CK_XOFF;
         end else if (halted && level <= resume_lvl) begin
            halted    <= 1'b0;
            pend_v    <= 1'b1;
            pend_kind <= CK_XON;
         end
      end else if (ack) begin
         pend_v <= 1'b0;
      end
   end

   // R3
   xoff_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_v) && pend_kind == CK_XOFF) |-> !$past(halted));
   // R4
   xon_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_v) && pend_kind == CK_XON) |-> $past(halted));
endmodule

// File: rtl/swfc_tx_arb.sv
module swfc_tx_arb
   import swfc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pend_v,
   input  ctrl_kind_e        pend_kind,
   input  logic [DATA_W-1:0] xon_code,
   input  logic [DATA_W-1:0] xoff_code,
   input  logic              paused,
   input  logic              dat_valid,
   input  logic [DATA_W-1:0] dat_char,
   input  logic              tx_gnt,
   output logic              ack,
   output logic              dat_take,
   output logic              tx_req,
   output logic [DATA_W-1:0] tx_char,
   output logic              tx_is_ctrl
);
   logic data_ok;
   logic [DATA_W-1:0] ctrl_code;

   assign data_ok    = dat_valid && !paused;
   assign ctrl_code  = (pend_kind == CK_XON) ? xon_code : xoff_code;
   assign tx_req     = pend_v || data_ok;
   assign tx_is_ctrl = pend_v;
   assign tx_char    = pend_v ? ctrl_code : dat_char;
   assign ack        = tx_gnt && pend_v;
   assign dat_take   = tx_gnt && data_ok && !pend_v;

   // R6
   take_on_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_take |-> (tx_gnt && dat_valid));
   // R9
   paused_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      paused |-> !dat_take);
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl
   import swfc_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int FIFO_DEPTH    = 64,
   parameter bit ANY_RESUME_EN = 1'b1,
   localparam int LVL_W        = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_any_resume,
   input  logic [DATA_W-1:0] cfg_xon_code,
   input  logic [DATA_W-1:0] cfg_xoff_code,
   input  logic [LVL_W-1:0]  cfg_halt_lvl,
   input  logic [LVL_W-1:0]  cfg_resume_lvl,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [LVL_W-1:0]  rx_fifo_level,
   output logic              fifo_wr_en,
   output logic [DATA_W-1:0] fifo_wr_data,
   input  logic              dat_valid,
   input  logic [DATA_W-1:0] dat_char,
   output logic              dat_take,
   output logic              tx_req,
   output logic [DATA_W-1:0] tx_char,
   output logic              tx_is_ctrl,
   input  logic              tx_gnt,
   output logic              tx_paused
);
   generate
      if (DATA_W < 5 || DATA_W > 8) begin : g_bad_width
         $error("swfc_ctrl: DATA_W must lie in 5..8");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("swfc_ctrl: FIFO_DEPTH must be at least 2");
      end
   endgenerate

   logic       pend_v, ack;
   ctrl_kind_e pend_kind;

   swfc_rx_filter #(.DATA_W(DATA_W), .ANY_RESUME_EN(ANY_RESUME_EN)) u_filt (
      .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .any_resume(cfg_any_resume),
      .xon_code(cfg_xon_code), .xoff_code(cfg_xoff_code),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .wr_en(fifo_wr_en), .wr_data(fifo_wr_data), .paused(tx_paused));

   swfc_level_mon #(.LVL_W(LVL_W)) u_lvl (
      .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .level(rx_fifo_level),
      .halt_lvl(cfg_halt_lvl), .resume_lvl(cfg_resume_lvl), .ack(ack),
      .pend_v(pend_v), .pend_kind(pend_kind));

   swfc_tx_arb #(.DATA_W(DATA_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .pend_v(pend_v), .pend_kind(pend_kind),
      .xon_code(cfg_xon_code), .xoff_code(cfg_xoff_code), .paused(tx_paused),
      .dat_valid(dat_valid), .dat_char(dat_char), .tx_gnt(tx_gnt),
      .ack(ack), .dat_take(dat_take), .tx_req(tx_req), .tx_char(tx_char),
      .tx_is_ctrl(tx_is_ctrl));

   // R12
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> (!tx_is_ctrl && !tx_paused) || cfg_enable);
   // R5
   ctrl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_is_ctrl |-> !dat_take);
endmodule

// File: tb/swfc_ctrl_tb_top.sv
module swfc_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_enable = 1'b0, cfg_any_resume = 1'b0;
   logic [7:0] cfg_xon_code = 8'h11, cfg_xoff_code = 8'h13;
   logic [6:0] cfg_halt_lvl = 7'd48, cfg_resume_lvl = 7'd16;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic [6:0] rx_fifo_level = 7'd0;
   logic       fifo_wr_en;
   logic [7:0] fifo_wr_data;
   logic       dat_valid = 1'b0;
   logic [7:0] dat_char = 8'h00;
   logic       dat_take, tx_req, tx_is_ctrl, tx_paused;
   logic [7:0] tx_char;
   logic       tx_gnt = 1'b0;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   swfc_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_any_resume(cfg_any_resume),
      .cfg_xon_code(cfg_xon_code), .cfg_xoff_code(cfg_xoff_code),
      .cfg_halt_lvl(cfg_halt_lvl), .cfg_resume_lvl(cfg_resume_lvl),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_fifo_level(rx_fifo_level),
      .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
      .dat_valid(dat_valid), .dat_char(dat_char), .dat_take(dat_take),
      .tx_req(tx_req), .tx_char(tx_char), .tx_is_ctrl(tx_is_ctrl),
      .tx_gnt(tx_gnt), .tx_paused(tx_paused));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // restart the flow state by a one-cycle disable
   task automatic restart();
      cfg_enable = 1'b0;
      rx_fifo_level = 7'd0;
      rx_valid = 1'b0;
      dat_valid = 1'b0;
      tick();
      cfg_enable = 1'b1;
      tick();
   endtask

   // drive one received byte for one cycle; returns write strobe seen
   task automatic rx_byte(input logic [7:0] b, output logic wr);
      rx_valid = 1'b1;
      rx_data  = b;
      #1 wr = fifo_wr_en;
      tick();
      rx_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic wr;
      int   nxoff, lxoff, nxon, lxon;
      tick();
      #1;
      // R1
      check("R1 tx_req", int'(tx_req), 0);
      check("R1 paused", int'(tx_paused), 0);
      check("R1 wr_en", int'(fifo_wr_en), 0);
      check("R1 dat_take", int'(dat_take), 0);
      tick();
      rst_n = 1'b1;
      cfg_enable = 1'b1;
      tick();

      // R2 R3 R4: sweep halt thresholds, resume = halt/2
      tx_gnt = 1'b1;
      for (int h = 1; h <= 64; h++) begin
         cfg_halt_lvl   = 7'(h);
         cfg_resume_lvl = 7'(h / 2);
         restart();
         nxoff = 0; lxoff = -1; nxon = 0; lxon = -1;
         for (int s = 0; s <= 128; s++) begin
            int lv;
            lv = (s <= 64) ? s : 128 - s;
            rx_fifo_level = 7'(lv);
            tick();
            if (tx_req && tx_is_ctrl) begin
               if (tx_char == cfg_xoff_code) begin nxoff++; if (lxoff < 0) lxoff = lv; end
               else if (tx_char == cfg_xon_code) begin nxon++; if (lxon < 0) lxon = lv; end
            end
         end
         check("R3 one xoff", nxoff, 1);
         check("R2 xoff level", lxoff, h);
         check("R4 one xon", nxon, 1);
         check("R4 xon level", lxon, h / 2);
      end

      // R13: code sweep
      cfg_halt_lvl = 7'd1;
      cfg_resume_lvl = 7'd0;
      cfg_any_resume = 1'b0;
      for (int k = 0; k < 256; k += 15) begin
         cfg_xoff_code = 8'(k);
         cfg_xon_code  = 8'(k + 7);
         restart();
         rx_fifo_level = 7'd1;
         tick();
         check("R13 xoff code", int'(tx_char), k);
         check("R13 xoff ctrl", int'(tx_is_ctrl), 1);
         rx_fifo_level = 7'd0;
         tick();
         tick();
         check("R13 xon code", int'(tx_char), (k + 7) % 256);
         rx_byte(8'(k), wr);
         check("R7 xoff consumed", int'(wr), 0);
         check("R7 paused", int'(tx_paused), 1);
         rx_byte(8'(k + 7), wr);
         check("R8 xon consumed", int'(wr), 0);
         check("R8 resumed", int'(tx_paused), 0);
      end
      cfg_xoff_code = 8'h13;
      cfg_xon_code  = 8'h11;

      // R5 R6: control code beats pending data
      cfg_halt_lvl = 7'd40;
      cfg_resume_lvl = 7'd10;
      restart();
      tx_gnt = 1'b0;
      dat_valid = 1'b1;
      dat_char = 8'h5A;
      #1;
      check("R6 no take without gnt", int'(dat_take), 0);
      check("R6 data offered", int'(tx_char), 8'h5A);
      rx_fifo_level = 7'd40;
      tick();
      #1;
      check("R5 ctrl code wins", int'(tx_char), 8'h13);
      check("R5 is_ctrl", int'(tx_is_ctrl), 1);
      tx_gnt = 1'b1;
      #1;
      check("R5 no data take", int'(dat_take), 0);
      tick();
      #1;
      check("R6 data take after ctrl", int'(dat_take), 1);
      check("R6 data char", int'(tx_char), 8'h5A);

      // R9: pause blocks data but not control
      restart();
      dat_valid = 1'b1;
      rx_byte(8'h13, wr);
      #1;
      check("R9 data held", int'(tx_req), 0);
      check("R9 no take", int'(dat_take), 0);
      tx_gnt = 1'b0;
      rx_fifo_level = 7'd40;
      tick();
      #1;
      check("R9 ctrl while paused", int'(tx_req), 1);
      check("R9 ctrl code", int'(tx_char), 8'h13);
      tx_gnt = 1'b1;
      dat_valid = 1'b0;

      // R11: any-resume off
      restart();
      cfg_any_resume = 1'b0;
      rx_byte(8'h13, wr);
      rx_byte(8'h41, wr);
      check("R11 stored", int'(wr), 1);
      check("R11 still paused", int'(tx_paused), 1);
      // R10: any-resume on
      cfg_any_resume = 1'b1;
      rx_byte(8'h42, wr);
      check("R10 stored", int'(wr), 1);
      check("R10 resumed", int'(tx_paused), 0);
      cfg_any_resume = 1'b0;

      // R12: disabled
      cfg_enable = 1'b0;
      rx_fifo_level = 7'd64;
      tick();
      rx_byte(8'h13, wr);
      check("R12 xoff passes", int'(wr), 1);
      check("R12 not paused", int'(tx_paused), 0);
      check("R12 no ctrl", int'(tx_req), 0);
      tick();
      check("R12 still no ctrl", int'(tx_is_ctrl), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule